// File: doc/BRIEF.md
# Conditional Vector Write-back Unit

This unit is the last stage of a shader ALU. It takes a four-component single-precision result and writes it into a 64-entry temporary register file. Each component goes through a power-of-two output scale and an optional clamp to the range 0.0 to 1.0. It is written only if two things hold: its write-mask bit is set, and a condition test on a selected condition-code component passes.

A four-component condition-code register records, for each component, whether the last value written to it was less than, equal to or greater than zero. An instruction can refresh that register from its own scaled result. A no-destination flag lets an instruction update the condition codes without touching the register file. Two combinational read ports give the source-read stage access to any entry.

Top module: `vec_writeback`

## Requirements
- R1: After reset, every register entry reads as 128'h0. The condition-code output `cc_o` reads 8'h55, which means every component holds code 1 (equal).
- R2: Component c of `result_i` sits at bits [32c+31:32c]. Mask bit c is `wmask_i[c]`. On a clock edge with `valid_i` high, component c of entry `dst_idx_i` is written only when its mask bit is set and its condition test passes. All other components of that entry keep their values.
- R3: A condition-code component stores 0 for less, 1 for equal and 2 for greater. Component c of the condition-code register sits at `cc_o[2c+1:2c]`. A component passes when bit k of `cc_test_i` is set and the tested code is k (bit 0 less, bit 1 equal, bit 2 greater). Test 0 never passes and test 7 always passes. The other tests are 1 LT, 2 EQ, 3 LE, 4 GT, 5 NE and 6 GE.
- R4: Field `cc_swz_i[2c+1:2c]` selects which condition-code component destination component c tests. The identity value is 8'hE4. Tests use the condition codes held before the current instruction's update.
- R5: Scale code `scale_i` values 0, 1, 2 and 3 multiply by 1, 2, 4 and 8. Values 5, 6 and 7 multiply by 1/2, 1/4 and 1/8. Value 4 multiplies by 1.
- R6: Scaling adjusts only the exponent. The following pass through unchanged: zeros, infinities and NaNs. A denormal input becomes a zero of the same sign. An exponent overflow gives an infinity of the same sign, and an underflow gives a zero of the same sign.
- R7: With `sat_i` set, the scaled value is clamped. A negative value or a NaN becomes +0.0. A value of 1.0 or more becomes 1.0 (32'h3F800000). Other values pass unchanged.
- R8: With `cc_set_i` set, each component whose mask bit is set and whose test passes loads a new condition code into the condition-code register. The code is taken from the final (scaled and clamped) value: zero exponent gives equal, otherwise the sign bit gives less or greater.
- R9: With `no_dst_i` set, nothing is written to the register file. The condition-code update of R8 still happens.
- R10: The two read ports return entry `rd_a_idx_i` and entry `rd_b_idx_i` combinationally and independently of each other.
- R11: With `valid_i` low, neither the register file nor the condition-code register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| dst_idx_i | input | 6 | Destination entry |
| wmask_i | input | 4 | Per-component write mask |
| scale_i | input | 3 | Output scale code |
| sat_i | input | 1 | Clamp to [0,1] |
| cc_set_i | input | 1 | Update the condition codes |
| no_dst_i | input | 1 | Suppress the register write |
| cc_test_i | input | 3 | Less/equal/greater test enables |
| cc_swz_i | input | 8 | Condition-code swizzle, 2 bits per component |
| result_i | input | 128 | ALU result, x in the low 32 bits |
| rd_a_idx_i | input | 6 | Read port A entry |
| rd_a_data_o | output | 128 | Read port A data |
| rd_b_idx_i | input | 6 | Read port B entry |
| rd_b_data_o | output | 128 | Read port B data |
| cc_o | output | 8 | Condition-code register, 2 bits per component |

## Verification
A wrong condition-code component stays hidden until a later instruction's test or swizzle selects it. It then shows up as a missing or extra component in the next write, one read cycle after that instruction's edge. `cc_o` makes the same fault visible immediately after the updating edge. A fault in the scale or clamp path shows on a read port in the cycle after the write, but only for the affected components. The mask and the condition test can each hide such a fault, so the stimulus checks every component of every entry it writes.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int COMP  = 4;
  localparam int DW    = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int CC_W  = 2;
  localparam int VW    = COMP * DW;
  localparam int CCV_W = COMP * CC_W;

  localparam logic [CC_W-1:0] CC_LT = 2'd0;
  localparam logic [CC_W-1:0] CC_EQ = 2'd1;
  localparam logic [CC_W-1:0] CC_GT = 2'd2;

  localparam logic [DW-1:0] FP_ONE = 32'h3F80_0000;

  function automatic logic [CC_W-1:0] cc_of(input logic [DW-1:0] v);
    if (v[DW-2 -: EXP_W] == '0) return CC_EQ;
    return v[DW-1] ? CC_LT : CC_GT;
  endfunction
endpackage

// File: rtl/vwb_scale_sat.sv
module vwb_scale_sat
  import wb_pkg::*;
(
  input  logic [DW-1:0] val_i,
  input  logic [2:0]    scale_i,
  input  logic          sat_i,
  output logic [DW-1:0] val_o
);
  localparam int EW = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic             sgn;
  logic [EXP_W-1:0] exp_in;
  logic [MAN_W-1:0] man_in;
  logic [EW-1:0]    up, dn;
  logic signed [EW-1:0] exp_new;
  logic [DW-1:0]    scaled;
  logic             is_nan;

  assign sgn    = val_i[DW-1];
  assign exp_in = val_i[DW-2 -: EXP_W];
  assign man_in = val_i[MAN_W-1:0];
  assign up     = (scale_i <= 3'd3) ? EW'(scale_i) : '0;
  assign dn     = (scale_i >= 3'd5) ? EW'(scale_i - 3'd4) : '0;
  assign exp_new = $signed({2'b00, exp_in} + up - dn);

  always_comb begin
    if (exp_in == '0)                          scaled = {sgn, {(DW-1){1'b0}}};
    else if (exp_in == EXP_MAX)                scaled = val_i;
    else if (exp_new >= $signed(EW'(EXP_MAX))) scaled = {sgn, EXP_MAX, {MAN_W{1'b0}}};
    else if (exp_new <= 0)                     scaled = {sgn, {(DW-1){1'b0}}};
    else                                       scaled = {sgn, exp_new[EXP_W-1:0], man_in};
  end

  assign is_nan = (scaled[DW-2 -: EXP_W] == EXP_MAX) && (scaled[MAN_W-1:0] != '0);

  always_comb begin
    val_o = scaled;
    if (sat_i) begin
      if (scaled[DW-1] || is_nan)            val_o = '0;
      else if (scaled[DW-2:0] >= FP_ONE[DW-2:0]) val_o = FP_ONE;
    end
  end
endmodule

// File: rtl/vwb_cond_eval.sv
module vwb_cond_eval
  import wb_pkg::*;
(
  input  logic [CCV_W-1:0] cc_i,
  input  logic [2:0]       test_i,
  input  logic [CCV_W-1:0] swz_i,
  output logic [COMP-1:0]  pass_o
);
  for (genvar c = 0; c < COMP; c++) begin : g_comp
    logic [1:0]      sel;
    logic [CC_W-1:0] code;
    assign sel  = swz_i[c*2 +: 2];
    assign code = cc_i[sel*CC_W +: CC_W];
    always_comb begin
      case (code)
        CC_LT:   pass_o[c] = test_i[0];
        CC_EQ:   pass_o[c] = test_i[1];
        CC_GT:   pass_o[c] = test_i[2];
        default: pass_o[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vwb_regfile.sv
module vwb_regfile
  import wb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [COMP-1:0] we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [VW-1:0]   wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  output logic [VW-1:0]   rdata_a_o,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [VW-1:0]   rdata_b_o
);
  logic [VW-1:0] mem_q [DEPTH];

  for (genvar c = 0; c < COMP; c++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i][c*DW +: DW] <= '0;
      end else if (we_i[c]) begin
        mem_q[waddr_i][c*DW +: DW] <= wdata_i[c*DW +: DW];
      end
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/vec_writeback.sv
module vec_writeback
  import wb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [AW-1:0]    dst_idx_i,
  input  logic [COMP-1:0]  wmask_i,
  input  logic [2:0]       scale_i,
  input  logic             sat_i,
  input  logic             cc_set_i,
  input  logic             no_dst_i,
  input  logic [2:0]       cc_test_i,
  input  logic [CCV_W-1:0] cc_swz_i,
  input  logic [VW-1:0]    result_i,
  input  logic [AW-1:0]    rd_a_idx_i,
  output logic [VW-1:0]    rd_a_data_o,
  input  logic [AW-1:0]    rd_b_idx_i,
  output logic [VW-1:0]    rd_b_data_o,
  output logic [CCV_W-1:0] cc_o
);
  logic [VW-1:0]    final_val;
  logic [COMP-1:0]  pass, act, we;
  logic [CCV_W-1:0] cc_q;

  for (genvar c = 0; c < COMP; c++) begin : g_lane
    vwb_scale_sat u_scale (
      .val_i   (result_i[c*DW +: DW]),
      .scale_i (scale_i),
      .sat_i   (sat_i),
      .val_o   (final_val[c*DW +: DW])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cc_q[c*CC_W +: CC_W] <= CC_EQ;
      else if (act[c] && cc_set_i) cc_q[c*CC_W +: CC_W] <= cc_of(final_val[c*DW +: DW]);
    end

    // R1
    cc_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cc_q[c*CC_W +: CC_W] != 2'b11);
    // R7
    sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sat_i |-> (!final_val[c*DW+DW-1] && final_val[c*DW +: DW-1] <= FP_ONE[DW-2:0]));
    // R6
    flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (final_val[c*DW+MAN_W +: EXP_W] == '0) |-> (final_val[c*DW +: MAN_W] == '0));
  end

  vwb_cond_eval u_cond (
    .cc_i   (cc_q),
    .test_i (cc_test_i),
    .swz_i  (cc_swz_i),
    .pass_o (pass)
  );

  assign act = {COMP{valid_i}} & wmask_i & pass;
  assign we  = act & {COMP{~no_dst_i}};

  vwb_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (dst_idx_i),
    .wdata_i   (final_val),
    .raddr_a_i (rd_a_idx_i),
    .rdata_a_o (rd_a_data_o),
    .raddr_b_i (rd_b_idx_i),
    .rdata_b_o (rd_b_data_o)
  );

  assign cc_o = cc_q;

  // R3
  never_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_test_i == 3'd0) |-> (pass == '0));
  // R3
  always_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_test_i == 3'd7) |-> (pass == '1));
  // R11
  idle_cc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cc_q));
endmodule

// File: tb/vec_writeback_bench.sv
module vec_writeback_bench;
  typedef struct packed {
    logic [5:0]   idx;
    logic [3:0]   mask;
    logic [2:0]   scl;
    logic         sat;
    logic         ccs;
    logic         nod;
    logic [2:0]   tst;
    logic [7:0]   swz;
    logic [127:0] res;
    logic [127:0] exp;
    logic [7:0]   cc;
    logic [3:0]   req;
  } vec_t;

  localparam int N = 15;
  localparam vec_t TBL [N] = '{
    // R2 R8: full write, cc from signs
    '{6'd1, 4'hF, 3'd0, 1'b0, 1'b1, 1'b0, 3'd7, 8'hE4,
      {32'hC0000000, 32'h0, 32'h3FC00000, 32'h3F800000},
      {32'hC0000000, 32'h0, 32'h3FC00000, 32'h3F800000}, 8'h1A, 4'd8},
    // R5: 2x
    '{6'd2, 4'hF, 3'd1, 1'b0, 1'b0, 1'b0, 3'd7, 8'hE4,
      {4{32'h3F800000}}, {4{32'h40000000}}, 8'h1A, 4'd5},
    // R3: GT identity
    '{6'd3, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0, 3'd4, 8'hE4,
      {4{32'h40400000}}, {32'h0, 32'h0, 32'h40400000, 32'h40400000}, 8'h1A, 4'd3},
    // R4: LT tests x for all -> none
    '{6'd4, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0, 3'd1, 8'h00,
      {4{32'h3F800000}}, 128'h0, 8'h1A, 4'd4},
    // R4 R5: LT tests w for all, 1/8
    '{6'd4, 4'hF, 3'd7, 1'b0, 1'b0, 1'b0, 3'd1, 8'hFF,
      {4{32'h3F000000}}, {4{32'h3D800000}}, 8'h1A, 4'd4},
    // R2 R5: mask x,z, 8x
    '{6'd5, 4'h5, 3'd3, 1'b0, 1'b0, 1'b0, 3'd7, 8'hE4,
      {4{32'h3F800000}}, {32'h0, 32'h41000000, 32'h0, 32'h41000000}, 8'h1A, 4'd2},
    // R5: code 4 is 1x
    '{6'd6, 4'hF, 3'd4, 1'b0, 1'b0, 1'b0, 3'd7, 8'hE4,
      {4{32'h3FC00000}}, {4{32'h3FC00000}}, 8'h1A, 4'd5},
    // R7: saturate after 2x
    '{6'd7, 4'hF, 3'd1, 1'b1, 1'b0, 1'b0, 3'd7, 8'hE4,
      {32'h3F400000, 32'h40400000, 32'h3F000000, 32'hBF800000},
      {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h0}, 8'h1A, 4'd7},
    // R9: no dst, cc still updated
    '{6'd8, 4'hF, 3'd0, 1'b0, 1'b1, 1'b1, 3'd7, 8'hE4,
      {32'hBF800000, 32'h3F800000, 32'h0, 32'hBF800000}, 128'h0, 8'h24, 4'd9},
    // R8: cc update limited to mask
    '{6'd9, 4'h2, 3'd0, 1'b0, 1'b1, 1'b0, 3'd7, 8'hE4,
      {4{32'hC0400000}}, {32'h0, 32'h0, 32'hC0400000, 32'h0}, 8'h20, 4'd8},
    // R6: overflow to inf, inf passes
    '{6'd10, 4'hF, 3'd3, 1'b0, 1'b0, 1'b0, 3'd7, 8'hE4,
      {32'h0, 32'h7F800000, 32'hFF000000, 32'h7F000000},
      {32'h0, 32'h7F800000, 32'hFF800000, 32'h7F800000}, 8'h20, 4'd6},
    // R6: underflow to signed zero
    '{6'd11, 4'hF, 3'd7, 1'b0, 1'b0, 1'b0, 3'd7, 8'hE4,
      {32'h02000000, 32'h01000000, 32'h80800001, 32'h00800000},
      {32'h00800000, 32'h0, 32'h80000000, 32'h0}, 8'h20, 4'd6},
    // R4: GE with mixed swizzle
    '{6'd12, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0, 3'd6, 8'h89,
      {4{32'h3F800000}}, {32'h3F800000, 32'h0, 32'h3F800000, 32'h0}, 8'h20, 4'd4},
    // R3: test 0 never passes
    '{6'd13, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hE4,
      {4{32'h3F800000}}, 128'h0, 8'h20, 4'd3},
    // R3: LE identity
    '{6'd14, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0, 3'd3, 8'hE4,
      {4{32'h40000000}}, {32'h40000000, 32'h0, 32'h40000000, 32'h40000000}, 8'h20, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, sat = 1'b0, ccs = 1'b0, nod = 1'b0;
  logic [5:0] idx = '0, ra = '0, rb = '0;
  logic [3:0] mask = '0;
  logic [2:0] scl = '0, tst = '0;
  logic [7:0] swz = '0;
  logic [127:0] res = '0;
  logic [127:0] rda, rdb;
  logic [7:0] cc;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_writeback u_vec_writeback (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .dst_idx_i(idx), .wmask_i(mask),
    .scale_i(scl), .sat_i(sat), .cc_set_i(ccs), .no_dst_i(nod), .cc_test_i(tst),
    .cc_swz_i(swz), .result_i(res), .rd_a_idx_i(ra), .rd_a_data_o(rda),
    .rd_b_idx_i(rb), .rd_b_data_o(rdb), .cc_o(cc)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ra = 6'd0; rb = 6'd63; #1;
    chk("R1 entry0", rda, 128'h0);
    chk("R1 entry63", rdb, 128'h0);
    chk("R1 cc", {120'h0, cc}, {120'h0, 8'h55});

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      valid = 1'b1; idx = TBL[i].idx; mask = TBL[i].mask; scl = TBL[i].scl;
      sat = TBL[i].sat; ccs = TBL[i].ccs; nod = TBL[i].nod; tst = TBL[i].tst;
      swz = TBL[i].swz; res = TBL[i].res;
      @(negedge clk);
      valid = 1'b0; ra = TBL[i].idx; #1;
      chk($sformatf("R%0d data vec%0d", TBL[i].req, i), rda, TBL[i].exp);
      chk($sformatf("R%0d cc vec%0d", TBL[i].req, i), {120'h0, cc}, {120'h0, TBL[i].cc});
    end

    // R11: valid low has no effect
    @(negedge clk);
    idx = 6'd20; mask = 4'hF; tst = 3'd7; swz = 8'hE4; ccs = 1'b1; nod = 1'b0;
    scl = 3'd0; sat = 1'b0; res = {4{32'hBF800000}};
    @(negedge clk);
    ra = 6'd20; #1;
    chk("R11 data", rda, 128'h0);
    chk("R11 cc", {120'h0, cc}, {120'h0, 8'h20});

    // R10: two ports read different entries at once
    ra = 6'd1; rb = 6'd5; #1;
    chk("R10 port a", rda, {32'hC0000000, 32'h0, 32'h3FC00000, 32'h3F800000});
    chk("R10 port b", rdb, {32'h0, 32'h41000000, 32'h0, 32'h41000000});
    rb = 6'd63; #1;
    chk("R1 unwritten entry", rdb, 128'h0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule